// File: doc/BRIEF.md
# JTAG Scan Monitor

This block watches the five lines of a JTAG test port (TCK, TMS, TDI, TDO and the active-low TRST) without driving any of them. A fast system clock samples the lines and tracks the test access port controller from TMS. The monitor collects the bits that move on TDI and TDO during instruction-register (IR) and data-register (DR) scans. At the end of each scan it hands the bits to a downstream consumer as records.

Each record carries a direction (TDI or TDO), the scan type, the bit count, an overflow mark and the captured bits. Every controller advance also produces a one-cycle strobe with the new state code, so a trace unit can log the full walk through the controller. The system clock must run at least four times faster than TCK.

Top module: `jtag_scan_monitor`

## Requirements
- R1: All five lines pass through two-flop synchronizers. The first TCK level sampled after reset only records the level and never counts as an edge, so a TCK held high out of reset does not advance the controller.
- R2: The tracked controller starts in reset and takes one step per rising TCK edge, using the TMS value seen at that edge. State codes: 0 reset, 1 idle, 2 select-DR, 3 capture-DR, 4 shift-DR, 5 exit1-DR, 6 pause-DR, 7 exit2-DR, 8 update-DR, 9 select-IR, 10 capture-IR, 11 shift-IR, 12 exit1-IR, 13 pause-IR, 14 exit2-IR, 15 update-IR. The standard TMS transitions apply; for example, select-IR goes to reset when TMS=1.
- R3: After every step, `state_vld_o` is high for exactly one cycle while `state_o` shows the new code. This includes steps that stay in the same state.
- R4: On a rising TCK edge taken while in shift-DR or shift-IR, including the edge that leaves for exit1, the TDI bit is stored. The first bit goes to data bit 0 and later bits fill upward.
- R5: On a falling TCK edge taken while in shift-DR or shift-IR, the TDO bit is stored in a second, independent buffer with the same ordering.
- R6: A falling edge in exit1 emits the TDO record (`rec_is_tdo_o`=1). A rising edge in exit1 emits the TDI record (`rec_is_tdo_o`=0). `rec_is_ir_o`=1 marks an IR scan. Each emit clears its buffer, so a scan resumed from pause starts a fresh count. Unfilled data bits read 0.
- R7: When a scan shifts more than DEPTH bits, the count saturates at DEPTH, the data keeps the first DEPTH bits and `rec_ovf_o` is 1 in that record.
- R8: While the synchronized TRST is low, the controller is held in reset (code 0) without a strobe, and both buffers are cleared.
- R9: A record stays on `rec_valid_o` with stable fields until `rec_ready_i` accepts it. A record produced while an earlier one is still waiting is discarded and sets the sticky `drop_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tck_i | input | 1 | Observed test clock |
| tms_i | input | 1 | Observed mode select |
| tdi_i | input | 1 | Observed serial data into the device |
| tdo_i | input | 1 | Observed serial data out of the device |
| trst_n_i | input | 1 | Observed active-low test reset |
| state_vld_o | output | 1 | One-cycle strobe after each controller step |
| state_o | output | 4 | Tracked controller state code |
| rec_valid_o | output | 1 | Record available |
| rec_ready_i | input | 1 | Consumer accepts the record |
| rec_is_tdo_o | output | 1 | 1 = TDO record, 0 = TDI record |
| rec_is_ir_o | output | 1 | 1 = IR scan, 0 = DR scan |
| rec_count_o | output | CW | Number of bits stored |
| rec_ovf_o | output | 1 | Scan was longer than DEPTH |
| rec_data_o | output | DEPTH | Captured bits, first bit at bit 0 |
| drop_o | output | 1 | Sticky: a record was lost |

## Verification
The controller is first walked through its select, reset and idle branches. This tells a wrong transition apart from a missing or doubled strobe. Full DR and IR scans use different, asymmetric TDI and TDO patterns, so swapped buffers, reversed bit order, a wrong scan-type tag and records in the wrong order each give a distinct mismatch. A scan that passes through pause, one longer than the buffer, one cut by TRST and one with the consumer stalled check buffer clearing, saturation, forced reset and the discard rule. Holding TCK high out of reset separates a correct first-level rule from one that treats the first sample as an edge.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

    typedef enum logic [3:0] {
        ST_RESET  = 4'd0,  ST_IDLE   = 4'd1,
        ST_SEL_DR = 4'd2,  ST_CAP_DR = 4'd3,  ST_SH_DR  = 4'd4,  ST_EX1_DR = 4'd5,
        ST_PA_DR  = 4'd6,  ST_EX2_DR = 4'd7,  ST_UPD_DR = 4'd8,
        ST_SEL_IR = 4'd9,  ST_CAP_IR = 4'd10, ST_SH_IR  = 4'd11, ST_EX1_IR = 4'd12,
        ST_PA_IR  = 4'd13, ST_EX2_IR = 4'd14, ST_UPD_IR = 4'd15
    } tap_state_e;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e r;
        case (s)
            ST_RESET:  r = tms ? ST_RESET  : ST_IDLE;
            ST_IDLE:   r = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_DR: r = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: r = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  r = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: r = tms ? ST_UPD_DR : ST_PA_DR;
            ST_PA_DR:  r = tms ? ST_EX2_DR : ST_PA_DR;
            ST_EX2_DR: r = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: r = tms ? ST_SEL_DR : ST_IDLE;
            ST_SEL_IR: r = tms ? ST_RESET  : ST_CAP_IR;
            ST_CAP_IR: r = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  r = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: r = tms ? ST_UPD_IR : ST_PA_IR;
            ST_PA_IR:  r = tms ? ST_EX2_IR : ST_PA_IR;
            ST_EX2_IR: r = tms ? ST_UPD_IR : ST_SH_IR;
            default:   r = tms ? ST_SEL_DR : ST_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jsm_sync.sv
module jsm_sync #(
    parameter int WIDTH = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o,
    output logic             valid_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
        logic [1:0]       fill;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d      = q;
        d.s1   = async_i;
        d.s2   = q.s1;
        d.fill = {q.fill[0], 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sync_o  = q.s2;
    assign valid_o = q.fill[1];
endmodule

// File: rtl/jsm_tap_tracker.sv
module jsm_tap_tracker
    import jsm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_valid_i,
    input  logic       tck_i,
    input  logic       tms_i,
    input  logic       trst_n_i,
    output logic       rise_o,
    output logic       fall_o,
    output logic       clear_o,
    output tap_state_e state_o,
    output logic       strobe_o
);
    typedef struct packed {
        logic       known;
        logic       prev;
        tap_state_e state;
        logic       strobe;
    } trk_t;

    trk_t q, d;
    logic rise, fall, hold_rst;

    always_comb begin
        hold_rst = smp_valid_i && !trst_n_i;
        rise     = smp_valid_i && q.known && !q.prev &&  tck_i && !hold_rst;
        fall     = smp_valid_i && q.known &&  q.prev && !tck_i && !hold_rst;
        d        = q;
        d.strobe = 1'b0;
        if (smp_valid_i) begin
            d.known = 1'b1;
            d.prev  = tck_i;
        end
        if (hold_rst) begin
            d.state = ST_RESET;
        end else if (rise) begin
            d.state  = tap_next(q.state, tms_i);
            d.strobe = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{known: 1'b0, prev: 1'b0, state: ST_RESET, strobe: 1'b0};
        else        q <= d;
    end

    assign rise_o   = rise;
    assign fall_o   = fall;
    assign clear_o  = hold_rst;
    assign state_o  = q.state;
    assign strobe_o = q.strobe;
endmodule

// File: rtl/jsm_capture.sv
module jsm_capture #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             take_i,
    input  logic             bit_i,
    input  logic             flush_i,
    output logic [DEPTH-1:0] data_o,
    output logic [CW-1:0]    count_o,
    output logic             ovf_o
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0] data;
        logic [CW-1:0]    cnt;
        logic             ovf;
    } cap_t;

    cap_t q, d;

    always_comb begin
        d = q;
        if (clear_i || flush_i) begin
            d = '0;
        end else if (take_i) begin
            if (q.cnt < CW'(DEPTH)) begin
                d.data[q.cnt[IW-1:0]] = bit_i;
                d.cnt = q.cnt + CW'(1);
            end else begin
                d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign data_o  = q.data;
    assign count_o = q.cnt;
    assign ovf_o   = q.ovf;
endmodule

// File: rtl/jsm_rec_port.sv
module jsm_rec_port #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             push_tdo_i,
    input  logic             push_ir_i,
    input  logic [CW-1:0]    push_cnt_i,
    input  logic             push_ovf_i,
    input  logic [DEPTH-1:0] push_data_i,
    input  logic             ready_i,
    output logic             valid_o,
    output logic             is_tdo_o,
    output logic             is_ir_o,
    output logic [CW-1:0]    count_o,
    output logic             ovf_o,
    output logic [DEPTH-1:0] data_o,
    output logic             drop_o
);
    typedef struct packed {
        logic             valid;
        logic             tdo;
        logic             ir;
        logic [CW-1:0]    cnt;
        logic             ovf;
        logic [DEPTH-1:0] data;
        logic             drop;
    } rec_t;

    rec_t q, d;

    always_comb begin
        d = q;
        if (q.valid && ready_i) d.valid = 1'b0;
        if (push_i) begin
            if (q.valid && !ready_i) begin
                d.drop = 1'b1;
            end else begin
                d.valid = 1'b1;
                d.tdo   = push_tdo_i;
                d.ir    = push_ir_i;
                d.cnt   = push_cnt_i;
                d.ovf   = push_ovf_i;
                d.data  = push_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid_o  = q.valid;
    assign is_tdo_o = q.tdo;
    assign is_ir_o  = q.ir;
    assign count_o  = q.cnt;
    assign ovf_o    = q.ovf;
    assign data_o   = q.data;
    assign drop_o   = q.drop;
endmodule

// File: rtl/jtag_scan_monitor.sv
module jtag_scan_monitor
    import jsm_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tck_i,
    input  logic             tms_i,
    input  logic             tdi_i,
    input  logic             tdo_i,
    input  logic             trst_n_i,
    output logic             state_vld_o,
    output logic [3:0]       state_o,
    output logic             rec_valid_o,
    input  logic             rec_ready_i,
    output logic             rec_is_tdo_o,
    output logic             rec_is_ir_o,
    output logic [CW-1:0]    rec_count_o,
    output logic             rec_ovf_o,
    output logic [DEPTH-1:0] rec_data_o,
    output logic             drop_o
);
    localparam int NLINES = 5;
    localparam int NBUF   = 2;   // buffer 0 holds TDI, buffer 1 holds TDO

    logic [NLINES-1:0] lines_s;
    logic              smp_valid;
    logic              rise, fall, clear;
    tap_state_e        cur_state;
    logic              in_shift, in_exit1, scan_ir;
    logic [NBUF-1:0]   take, flush, line_bit, ovf;
    logic [DEPTH-1:0]  data   [NBUF];
    logic [CW-1:0]     count  [NBUF];

    jsm_sync #(.WIDTH(NLINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({trst_n_i, tdo_i, tdi_i, tms_i, tck_i}),
        .sync_o  (lines_s),
        .valid_o (smp_valid)
    );

    jsm_tap_tracker u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid_i (smp_valid),
        .tck_i       (lines_s[0]),
        .tms_i       (lines_s[1]),
        .trst_n_i    (lines_s[4]),
        .rise_o      (rise),
        .fall_o      (fall),
        .clear_o     (clear),
        .state_o     (cur_state),
        .strobe_o    (state_vld_o)
    );

    always_comb begin
        in_shift = (cur_state == ST_SH_DR)  || (cur_state == ST_SH_IR);
        in_exit1 = (cur_state == ST_EX1_DR) || (cur_state == ST_EX1_IR);
        scan_ir  = (cur_state == ST_SH_IR)  || (cur_state == ST_EX1_IR);
        take     = {fall && in_shift, rise && in_shift};
        flush    = {fall && in_exit1, rise && in_exit1};
        line_bit = {lines_s[3], lines_s[2]};
    end

    for (genvar g = 0; g < NBUF; g++) begin : g_buf
        jsm_capture #(.DEPTH(DEPTH), .CW(CW)) u_cap (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear),
            .take_i  (take[g]),
            .bit_i   (line_bit[g]),
            .flush_i (flush[g]),
            .data_o  (data[g]),
            .count_o (count[g]),
            .ovf_o   (ovf[g])
        );
    end

    jsm_rec_port #(.DEPTH(DEPTH), .CW(CW)) u_rec (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (|flush),
        .push_tdo_i  (flush[1]),
        .push_ir_i   (scan_ir),
        .push_cnt_i  (flush[1] ? count[1] : count[0]),
        .push_ovf_i  (flush[1] ? ovf[1]   : ovf[0]),
        .push_data_i (flush[1] ? data[1]  : data[0]),
        .ready_i     (rec_ready_i),
        .valid_o     (rec_valid_o),
        .is_tdo_o    (rec_is_tdo_o),
        .is_ir_o     (rec_is_ir_o),
        .count_o     (rec_count_o),
        .ovf_o       (rec_ovf_o),
        .data_o      (rec_data_o),
        .drop_o      (drop_o)
    );

    assign state_o = cur_state;
endmodule

// File: rtl/jtag_scan_monitor_chk.sv
module jtag_scan_monitor_chk #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trst_n_i,
    input logic             state_vld_o,
    input logic [3:0]       state_o,
    input logic             rec_valid_o,
    input logic             rec_ready_i,
    input logic             rec_is_tdo_o,
    input logic [CW-1:0]    rec_count_o,
    input logic             rec_ovf_o,
    input logic [DEPTH-1:0] rec_data_o,
    input logic             drop_o
);
    logic [2:0] trst_low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            trst_low_q <= '0;
        else if (trst_n_i)     trst_low_q <= '0;
        else if (trst_low_q != 3'd7) trst_low_q <= trst_low_q + 3'd1;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        state_vld_o |=> !state_vld_o); // R3

    AST_SHIFT_DR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_vld_o && state_o == 4'd4) |->
            ($past(state_o) == 4'd3 || $past(state_o) == 4'd4 || $past(state_o) == 4'd7)); // R2

    AST_IR_EXIT_TO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_vld_o && state_o == 4'd0) |->
            ($past(state_o) == 4'd0 || $past(state_o) == 4'd9)); // R2

    AST_TRST_HOLDS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (trst_low_q >= 3'd5) |-> (state_o == 4'd0 && !state_vld_o)); // R8

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rec_valid_o |-> (rec_count_o <= CW'(DEPTH))); // R7

    AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_o && rec_ovf_o) |-> (rec_count_o == CW'(DEPTH))); // R7

    AST_REC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_valid_o && !rec_ready_i) |=>
            (rec_valid_o && $stable(rec_data_o) && $stable(rec_count_o) && $stable(rec_is_tdo_o))); // R9

    AST_DROP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |=> drop_o); // R9
endmodule

bind jtag_scan_monitor jtag_scan_monitor_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .trst_n_i     (trst_n_i),
    .state_vld_o  (state_vld_o),
    .state_o      (state_o),
    .rec_valid_o  (rec_valid_o),
    .rec_ready_i  (rec_ready_i),
    .rec_is_tdo_o (rec_is_tdo_o),
    .rec_count_o  (rec_count_o),
    .rec_ovf_o    (rec_ovf_o),
    .rec_data_o   (rec_data_o),
    .drop_o       (drop_o)
);

// File: tb/jtag_scan_monitor_bench.sv
`timescale 1ns/1ps
module jtag_scan_monitor_bench;
    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int HALF  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tck = 1'b1, tms = 1'b1, tdi = 1'b0, tdo = 1'b0, trst_n = 1'b1;
    logic rdy = 1'b1;
    logic state_vld, rec_valid, rec_tdo, rec_ir, rec_ovf, drop;
    logic [3:0] state;
    logic [CW-1:0] rec_cnt;
    logic [DEPTH-1:0] rec_data;

    int checks = 0;
    int fails  = 0;
    int strobes = 0;
    logic [3:0] last_strobe = 4'hF;

    typedef struct packed {
        logic tdo;
        logic ir;
        logic [CW-1:0] cnt;
        logic ovf;
        logic [DEPTH-1:0] data;
    } rec_t;
    rec_t recs[$];

    always #2.5 clk = ~clk;

    jtag_scan_monitor #(.DEPTH(DEPTH)) u_jtag_scan_monitor (
        .clk (clk), .rst_n (rst_n),
        .tck_i (tck), .tms_i (tms), .tdi_i (tdi), .tdo_i (tdo), .trst_n_i (trst_n),
        .state_vld_o (state_vld), .state_o (state),
        .rec_valid_o (rec_valid), .rec_ready_i (rdy),
        .rec_is_tdo_o (rec_tdo), .rec_is_ir_o (rec_ir),
        .rec_count_o (rec_cnt), .rec_ovf_o (rec_ovf), .rec_data_o (rec_data),
        .drop_o (drop)
    );

    always @(negedge clk) begin
        if (rst_n && state_vld) begin
            strobes++;
            last_strobe = state;
        end
        if (rst_n && rec_valid && rdy)
            recs.push_back('{tdo: rec_tdo, ir: rec_ir, cnt: rec_cnt, ovf: rec_ovf, data: rec_data});
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tcyc(input logic m, input logic di, input logic dout);
        tck = 1'b0; tms = m; tdi = di; tdo = dout;
        repeat (HALF) @(negedge clk);
        tck = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic go_idle();
        for (int i = 0; i < 5; i++) tcyc(1'b1, 1'b0, 1'b0);
        tcyc(1'b0, 1'b0, 1'b0);
    endtask

    task automatic scan(input bit ir, input int n, input logic [15:0] di, input logic [15:0] dout);
        tcyc(1'b1, 1'b0, 1'b0);
        if (ir) tcyc(1'b1, 1'b0, 1'b0);
        tcyc(1'b0, 1'b0, 1'b0);
        tcyc(1'b0, 1'b0, 1'b0);
        for (int k = 0; k < n; k++) tcyc(k == n - 1, di[k], dout[k]);
        tcyc(1'b1, 1'b0, 1'b0);
        tcyc(1'b0, 1'b0, 1'b0);
    endtask

    task automatic check_rec(input int idx, input string req, input logic t, input logic ir,
                             input int cnt, input logic ov, input logic [DEPTH-1:0] dat);
        rec_t r;
        check(recs.size() > idx, req, recs.size(), idx + 1);
        if (recs.size() > idx) begin
            r = recs[idx];
            check(r.tdo == t && r.ir == ir, req, {r.tdo, r.ir}, {t, ir});
            check(r.cnt == CW'(cnt) && r.ovf == ov, req, {r.cnt, r.ovf}, {CW'(cnt), ov});
            check(r.data == dat, req, r.data, dat);
        end
    endtask

    task automatic t_reset_state();
        repeat (20) @(negedge clk);
        check(state == 4'd0, "R1 held-high TCK no edge", state, 0);
        check(strobes == 0, "R1 no strobe at start", strobes, 0);
        check(!rec_valid && !drop, "R9 reset outputs", {rec_valid, drop}, 0);
    endtask

    task automatic t_walk();
        int s0;
        s0 = strobes;
        tcyc(1'b1, 1'b0, 1'b0);
        check(state == 4'd0 && strobes == s0 + 1 && last_strobe == 4'd0, "R3 reset self-step", state, 0);
        tcyc(1'b0, 1'b0, 1'b0);
        check(state == 4'd1 && last_strobe == 4'd1, "R2 reset->idle", state, 1);
        tcyc(1'b1, 1'b0, 1'b0);
        check(state == 4'd2, "R2 idle->selDR", state, 2);
        tcyc(1'b1, 1'b0, 1'b0);
        check(state == 4'd9, "R2 selDR->selIR", state, 9);
        tcyc(1'b1, 1'b0, 1'b0);
        check(state == 4'd0 && strobes == s0 + 5, "R3 selIR->reset strobes", strobes, s0 + 5);
    endtask

    task automatic t_dr_scan();
        recs.delete();
        go_idle();
        scan(1'b0, 5, 16'b10110, 16'b01011);
        check(recs.size() == 2, "R6 two records", recs.size(), 2);
        check_rec(0, "R5 DR TDO record", 1'b1, 1'b0, 5, 1'b0, 8'b01011);
        check_rec(1, "R4 DR TDI record", 1'b0, 1'b0, 5, 1'b0, 8'b10110);
        check(state == 4'd1, "R2 back to idle", state, 1);
    endtask

    task automatic t_ir_scan();
        recs.delete();
        scan(1'b1, 3, 16'b011, 16'b100);
        check_rec(0, "R6 IR TDO record", 1'b1, 1'b1, 3, 1'b0, 8'b100);
        check_rec(1, "R6 IR TDI record", 1'b0, 1'b1, 3, 1'b0, 8'b011);
    endtask

    task automatic t_pause();
        recs.delete();
        tcyc(1'b1, 1'b0, 1'b0);
        tcyc(1'b0, 1'b0, 1'b0);
        tcyc(1'b0, 1'b0, 1'b0);
        tcyc(1'b0, 1'b1, 1'b0);
        tcyc(1'b1, 1'b1, 1'b1);
        tcyc(1'b0, 1'b0, 1'b0);
        check(state == 4'd6, "R2 exit1->pause", state, 6);
        tcyc(1'b1, 1'b0, 1'b0);
        tcyc(1'b0, 1'b0, 1'b0);
        check(state == 4'd4, "R2 exit2->shift", state, 4);
        tcyc(1'b0, 1'b0, 1'b1);
        tcyc(1'b0, 1'b1, 1'b1);
        tcyc(1'b1, 1'b1, 1'b0);
        tcyc(1'b1, 1'b0, 1'b0);
        tcyc(1'b0, 1'b0, 1'b0);
        check(recs.size() == 4, "R6 pause record count", recs.size(), 4);
        check_rec(0, "R6 first TDO part", 1'b1, 1'b0, 2, 1'b0, 8'b10);
        check_rec(1, "R6 first TDI part", 1'b0, 1'b0, 2, 1'b0, 8'b11);
        check_rec(2, "R6 resumed TDO part", 1'b1, 1'b0, 3, 1'b0, 8'b011);
        check_rec(3, "R6 resumed TDI part", 1'b0, 1'b0, 3, 1'b0, 8'b110);
    endtask

    task automatic t_overflow();
        recs.delete();
        scan(1'b0, 11, 16'b101_1100_1010, 16'b010_0011_0101);
        check_rec(0, "R7 TDO saturated", 1'b1, 1'b0, 8, 1'b1, 8'b0011_0101);
        check_rec(1, "R7 TDI saturated", 1'b0, 1'b0, 8, 1'b1, 8'b1100_1010);
    endtask

    task automatic t_trst();
        int s0;
        recs.delete();
        tcyc(1'b1, 1'b0, 1'b0);
        tcyc(1'b0, 1'b0, 1'b0);
        tcyc(1'b0, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) tcyc(1'b0, 1'b1, 1'b1);
        s0 = strobes;
        trst_n = 1'b0;
        repeat (10) @(negedge clk);
        check(state == 4'd0 && strobes == s0, "R8 TRST forces reset, no strobe", state, 0);
        trst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(recs.size() == 0, "R8 no record on TRST", recs.size(), 0);
        tcyc(1'b0, 1'b0, 1'b0);
        scan(1'b0, 2, 16'b01, 16'b10);
        check_rec(0, "R8 TDO buffer cleared", 1'b1, 1'b0, 2, 1'b0, 8'b10);
        check_rec(1, "R8 TDI buffer cleared", 1'b0, 1'b0, 2, 1'b0, 8'b01);
    endtask

    task automatic t_drop();
        recs.delete();
        rdy = 1'b0;
        scan(1'b0, 4, 16'b1001, 16'b0110);
        check(rec_valid && drop, "R9 pending and dropped", {rec_valid, drop}, 3);
        check(rec_tdo && rec_cnt == CW'(4) && rec_data == 8'b0110, "R9 first record kept",
              rec_data, 8'b0110);
        rdy = 1'b1;
        repeat (4) @(negedge clk);
        check(recs.size() == 1 && !rec_valid, "R9 one record delivered", recs.size(), 1);
        check(drop, "R9 drop sticky", drop, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_walk();
        t_dr_scan();
        t_ir_scan();
        t_pause();
        t_overflow();
        t_trst();
        t_drop();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule